// File: doc/BRIEF.md
# Little-Endian Load/Store Lane Steering Unit

This unit sits between a processor core and a memory that is one 32-bit word wide and addressed by byte in little-endian order. It forms the effective address from a base register value and a signed 16-bit displacement. For a load, it picks the addressed byte or halfword out of the word returned by memory and widens it to the full data width. The widening either copies the field's top bit upward or fills with zeros. For a store, it produces per-lane write enables and a write word in which the source byte or halfword is copied onto every lane that might be written.

Access size is a two-bit code: 0 is byte, 1 is halfword, 2 is word and 3 is reserved. A separate flag picks sign extension for sub-word loads. Halfword and word accesses must be naturally aligned. A misaligned or reserved access raises an error flag, asserts no lane enables and returns a zero load value. All outputs are registered once, so results appear one clock after the inputs are presented.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address output equals the base input plus the 16-bit displacement sign-extended to 32 bits, wrapping modulo 2^32.
- R2: A word access (size code 2) with address bits [1:0] equal to 0 returns the read word unchanged, whatever the signed flag says, and enables all four lanes (enable value 4'b1111).
- R3: A byte access (size code 0) takes its field from read-data bits [8k+7:8k], where k is address bits [1:0]. Lane 0 is the lowest-addressed byte, so the word 0x11223344 reads back 0x44, 0x33, 0x22 and 0x11 at offsets 0 to 3.
- R4: For a byte load, a signed flag of 1 copies bit 7 of the field into bits [31:8], and a signed flag of 0 clears bits [31:8].
- R5: A halfword access (size code 1) with address bit 0 equal to 0 takes bits [15:0] when address bit 1 is 0 and bits [31:16] when it is 1. The signed flag copies bit 15 of the field into bits [31:16] when set and clears them when clear.
- R6: A word access with address bits [1:0] equal to 0 passes the store data to the write-data output unchanged.
- R7: A halfword access puts store bits [15:0] on both halves of the write data. When aligned, it enables lanes 4'b0011 if address bit 1 is 0 and 4'b1100 if it is 1.
- R8: A byte access copies store bits [7:0] onto all four lanes of the write data and enables exactly one lane, bit k of the enable output, where k is address bits [1:0].
- R9: A halfword access with address bit 0 set, a word access with address bits [1:0] non-zero, or any size-3 access raises the error output, drives the enable output to 0 and returns a load value of 0.
- R10: Every output is registered, so a change at the inputs shows at the outputs after the next rising clock edge and not before. An active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed address displacement |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| signed_i | input | 1 | 1 selects sign extension for sub-word loads |
| mem_rdata_i | input | 32 | Word read from memory |
| st_data_i | input | 32 | Store source register value |
| eaddr_o | output | 32 | Registered effective address |
| ld_data_o | output | 32 | Registered, extended load result |
| lane_en_o | output | 4 | Registered per-byte-lane enables |
| wr_data_o | output | 32 | Registered, lane-replicated write data |
| align_err_o | output | 1 | Registered misalignment/reserved-size error |

## Verification
The bench builds the unit with its default parameters: 32-bit data and addresses and a 16-bit displacement. With these, every lane offset, both halfword positions and every alignment fault can be reached with a small set of displacements. Negative displacements and a base near the top of the address space cover sign extension of the displacement and address wrap-around. Read words with the top bit of each lane set, placed next to words with those bits clear, make each extension choice show up in the upper bits.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] eaddr,
  output logic [LANE_W-1:0] lane,
  output logic              fault
);

  localparam int EXT_W = ADDR_W - DISP_W;

  // widen the displacement by copying its top bit
  function automatic logic [ADDR_W-1:0] widen_disp(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  // alignment rule: byte always ok, half needs bit 0 clear, word needs all lane bits clear
  function automatic logic is_misaligned(input acc_size_e s, input logic [LANE_W-1:0] l);
    case (s)
      ACC_BYTE: return 1'b0;
      ACC_HALF: return l[0];
      ACC_WORD: return |l;
      default:  return 1'b1;
    endcase
  endfunction

  assign eaddr = base + widen_disp(disp);
  assign lane  = eaddr[LANE_W-1:0];
  assign fault = is_misaligned(size, lane);

endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANE_W-1:0] lane,
  input  acc_size_e         size,
  input  logic              sext,
  input  logic              fault,
  output logic [DATA_W-1:0] result
);

  localparam int LANES  = DATA_W / 8;
  localparam int HALVES = LANES / 2;
  localparam int HSEL_W = (LANE_W > 1) ? LANE_W - 1 : 1;

  logic [7:0]  lane_byte [LANES];
  logic [15:0] lane_half [HALVES];
  logic [7:0]  pick_b;
  logic [15:0] pick_h;

  for (genvar g = 0; g < LANES; g++) begin : g_bytes
    assign lane_byte[g] = rdata[8*g +: 8];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_halves
    assign lane_half[h] = rdata[16*h +: 16];
  end

  function automatic logic [DATA_W-1:0] grow8(input logic [7:0] b, input logic s);
    return {{(DATA_W-8){s & b[7]}}, b};
  endfunction

  function automatic logic [DATA_W-1:0] grow16(input logic [15:0] v, input logic s);
    return {{(DATA_W-16){s & v[15]}}, v};
  endfunction

  logic [HSEL_W-1:0] half_idx;
  assign half_idx = HSEL_W'(lane >> 1);
  assign pick_b   = lane_byte[lane];
  assign pick_h   = lane_half[half_idx];

  always_comb begin
    result = '0;
    if (!fault) begin
      case (size)
        ACC_BYTE: result = grow8(pick_b, sext);
        ACC_HALF: result = grow16(pick_h, sext);
        ACC_WORD: result = rdata;
        default:  result = '0;
      endcase
    end
  end

endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [DATA_W-1:0]   sdata,
  input  logic [LANE_W-1:0]   lane,
  input  acc_size_e           size,
  input  logic                fault,
  output logic [DATA_W/8-1:0] lane_en,
  output logic [DATA_W-1:0]   wdata
);

  localparam int LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    always_comb begin
      case (size)
        ACC_BYTE: hit = (lane == LANE_W'(g));
        ACC_HALF: hit = ((lane >> 1) == LANE_W'(g / 2));
        ACC_WORD: hit = 1'b1;
        default:  hit = 1'b0;
      endcase
    end
    assign lane_en[g] = hit & ~fault;

    always_comb begin
      case (size)
        ACC_BYTE: wdata[8*g +: 8] = sdata[7:0];
        ACC_HALF: wdata[8*g +: 8] = sdata[8*(g % 2) +: 8];
        default:  wdata[8*g +: 8] = sdata[8*g +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [DISP_W-1:0]   disp_i,
  input  logic [1:0]          size_i,
  input  logic                signed_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic [DATA_W-1:0]   st_data_i,
  output logic [ADDR_W-1:0]   eaddr_o,
  output logic [DATA_W-1:0]   ld_data_o,
  output logic [DATA_W/8-1:0] lane_en_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic                align_err_o
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  acc_size_e           size_w;
  logic [ADDR_W-1:0]   eaddr_w;
  logic [LANE_W-1:0]   lane_w;
  logic                fault_w;
  logic [DATA_W-1:0]   load_w;
  logic [LANES-1:0]    en_w;
  logic [DATA_W-1:0]   wdata_w;

  assign size_w = acc_size_e'(size_i);

  lsu_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .LANE_W(LANE_W)) u_addr (
    .base  (base_i),
    .disp  (disp_i),
    .size  (size_w),
    .eaddr (eaddr_w),
    .lane  (lane_w),
    .fault (fault_w)
  );

  lsu_load_align #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_load (
    .rdata  (mem_rdata_i),
    .lane   (lane_w),
    .size   (size_w),
    .sext   (signed_i),
    .fault  (fault_w),
    .result (load_w)
  );

  lsu_store_align #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_store (
    .sdata   (st_data_i),
    .lane    (lane_w),
    .size    (size_w),
    .fault   (fault_w),
    .lane_en (en_w),
    .wdata   (wdata_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eaddr_o     <= '0;
      ld_data_o   <= '0;
      lane_en_o   <= '0;
      wr_data_o   <= '0;
      align_err_o <= 1'b0;
    end else begin
      eaddr_o     <= eaddr_w;
      ld_data_o   <= load_w;
      lane_en_o   <= en_w;
      wr_data_o   <= wdata_w;
      align_err_o <= fault_w;
    end
  end

  // R9
  fault_no_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_w |-> (en_w == '0 && load_w == '0));

  // R8
  byte_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_w == ACC_BYTE) |-> ($countones(en_w) == 1 && en_w[lane_w]));

  // R7
  half_pair_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_w == ACC_HALF && !fault_w) |-> ($countones(en_w) == 2 && en_w[lane_w] && en_w[lane_w + 1]));

  // R2
  word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_w == ACC_WORD && !fault_w) |-> (&en_w));

  // R4
  byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_w == ACC_BYTE && !signed_i) |-> (load_w[DATA_W-1:8] == '0));

  // R10
  load_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ld_data_o == $past(load_w) && lane_en_o == $past(en_w)));

endmodule

// File: tb/test_lsu_lane_unit.sv
module test_lsu_lane_unit;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] disp;
    logic [1:0]  size;
    logic        sgn;
    logic [31:0] rd;
    logic [31:0] sd;
    logic [31:0] x_ea;
    logic [31:0] x_ld;
    logic [3:0]  x_en;
    logic [31:0] x_wd;
    logic        x_err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h0020_0000, 16'h0004, 2'd2, 1'b0, 32'h1122_3344, 32'hDEAD_BEEF, 32'h0020_0004, 32'h1122_3344, 4'hF, 32'hDEAD_BEEF, 1'b0},
    '{32'h0020_0008, 16'hFFFC, 2'd0, 1'b0, 32'h8899_AABB, 32'hDEAD_BEEF, 32'h0020_0004, 32'h0000_00BB, 4'h1, 32'hEFEF_EFEF, 1'b0},
    '{32'h0020_0000, 16'h0001, 2'd0, 1'b1, 32'h8899_AABB, 32'hDEAD_BEEF, 32'h0020_0001, 32'hFFFF_FFAA, 4'h2, 32'hEFEF_EFEF, 1'b0},
    '{32'h0020_0000, 16'h0002, 2'd0, 1'b0, 32'h1122_3344, 32'hDEAD_BEEF, 32'h0020_0002, 32'h0000_0022, 4'h4, 32'hEFEF_EFEF, 1'b0},
    '{32'h0020_0000, 16'h0003, 2'd0, 1'b1, 32'h1122_3344, 32'hDEAD_BEEF, 32'h0020_0003, 32'h0000_0011, 4'h8, 32'hEFEF_EFEF, 1'b0},
    '{32'h0020_0000, 16'h0003, 2'd0, 1'b1, 32'h8899_AABB, 32'hDEAD_BEEF, 32'h0020_0003, 32'hFFFF_FF88, 4'h8, 32'hEFEF_EFEF, 1'b0},
    '{32'h0020_0000, 16'h0000, 2'd1, 1'b1, 32'h8899_AABB, 32'hDEAD_BEEF, 32'h0020_0000, 32'hFFFF_AABB, 4'h3, 32'hBEEF_BEEF, 1'b0},
    '{32'h0020_0000, 16'h0002, 2'd1, 1'b0, 32'h8899_AABB, 32'hDEAD_BEEF, 32'h0020_0002, 32'h0000_8899, 4'hC, 32'hBEEF_BEEF, 1'b0},
    '{32'h0020_0000, 16'h0002, 2'd1, 1'b1, 32'h1122_3344, 32'hDEAD_BEEF, 32'h0020_0002, 32'h0000_1122, 4'hC, 32'hBEEF_BEEF, 1'b0},
    '{32'h0020_0000, 16'h0000, 2'd1, 1'b0, 32'h1122_3344, 32'hDEAD_BEEF, 32'h0020_0000, 32'h0000_3344, 4'h3, 32'hBEEF_BEEF, 1'b0},
    '{32'h0020_0000, 16'h0001, 2'd1, 1'b1, 32'h8899_AABB, 32'hDEAD_BEEF, 32'h0020_0001, 32'h0000_0000, 4'h0, 32'hBEEF_BEEF, 1'b1},
    '{32'h0020_0000, 16'h0002, 2'd2, 1'b0, 32'h1122_3344, 32'hDEAD_BEEF, 32'h0020_0002, 32'h0000_0000, 4'h0, 32'hDEAD_BEEF, 1'b1},
    '{32'h0020_0000, 16'h0000, 2'd3, 1'b0, 32'h1122_3344, 32'hDEAD_BEEF, 32'h0020_0000, 32'h0000_0000, 4'h0, 32'hDEAD_BEEF, 1'b1},
    '{32'hFFFF_FFFE, 16'h0004, 2'd0, 1'b0, 32'h1122_3344, 32'hDEAD_BEEF, 32'h0000_0002, 32'h0000_0022, 4'h4, 32'hEFEF_EFEF, 1'b0},
    '{32'h0000_1000, 16'h8000, 2'd2, 1'b1, 32'h8899_AABB, 32'h0123_4567, 32'hFFFF_9000, 32'h8899_AABB, 4'hF, 32'h0123_4567, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic [1:0]  size_i = '0;
  logic        signed_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] st_data_i = '0;
  logic [31:0] eaddr_o;
  logic [31:0] ld_data_o;
  logic [3:0]  lane_en_o;
  logic [31:0] wr_data_o;
  logic        align_err_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_unit i_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .base_i(base_i), .disp_i(disp_i), .size_i(size_i),
    .signed_i(signed_i), .mem_rdata_i(mem_rdata_i), .st_data_i(st_data_i),
    .eaddr_o(eaddr_o), .ld_data_o(ld_data_o), .lane_en_o(lane_en_o),
    .wr_data_o(wr_data_o), .align_err_o(align_err_o)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic drive(input vec_t v);
    base_i = v.base; disp_i = v.disp; size_i = v.size; signed_i = v.sgn;
    mem_rdata_i = v.rd; st_data_i = v.sd;
  endtask

  function automatic string ld_tag(input vec_t v);
    if (v.x_err) return "R9";
    case (v.size)
      2'd0: return "R3 R4";
      2'd1: return "R5";
      default: return "R2";
    endcase
  endfunction

  function automatic string st_tag(input vec_t v);
    if (v.x_err) return "R9";
    case (v.size)
      2'd0: return "R8";
      2'd1: return "R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R10: reset clears everything
    drive(VECS[0]);
    repeat (2) @(negedge clk);
    check("R10", "reset eaddr", eaddr_o, 32'h0);
    check("R10", "reset load", ld_data_o, 32'h0);
    check("R10", "reset lanes", {28'h0, lane_en_o}, 32'h0);
    check("R10", "reset wdata", wr_data_o, 32'h0);
    check("R10", "reset err", {31'h0, align_err_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check("R1", "eaddr", eaddr_o, VECS[i].x_ea);
      check(ld_tag(VECS[i]), "load", ld_data_o, VECS[i].x_ld);
      check(st_tag(VECS[i]), "lanes", {28'h0, lane_en_o}, {28'h0, VECS[i].x_en});
      check(st_tag(VECS[i]), "wdata", wr_data_o, VECS[i].x_wd);
      check("R9", "err", {31'h0, align_err_o}, {31'h0, VECS[i].x_err});
    end

    // R10: outputs hold until the next rising edge
    drive(VECS[2]);
    #1;
    check("R10", "hold load", ld_data_o, VECS[NV-1].x_ld);
    check("R10", "hold lanes", {28'h0, lane_en_o}, {28'h0, VECS[NV-1].x_en});
    @(negedge clk);
    check("R10", "update load", ld_data_o, VECS[2].x_ld);

    // R2: signed flag has no effect on a word load
    drive(VECS[0]);
    signed_i = 1'b1;
    mem_rdata_i = 32'hF00D_8080;
    @(negedge clk);
    check("R2", "word signed", ld_data_o, 32'hF00D_8080);

    // R10: asynchronous reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R10", "async reset lanes", {28'h0, lane_en_o}, 32'h0);
    check("R10", "async reset load", ld_data_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    summary();
    $finish;
  end

endmodule